// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block arbitrates ownership of a parallel external memory bus between the local access engine and an outside master. The outside master pulls an active-low hold request. The controller synchronizes that request and stops the access engine from starting new cycles. It waits until every access already in flight has finished, then turns off the output drivers of the address, data and control pin groups. Only after that does it pull its active-low acknowledge. When the request is withdrawn, the steps run in reverse: the acknowledge is released first, the drivers are re-enabled one bus clock later, and normal accesses may start again one bus clock after that.

Everything runs on the single fast timing clock. The half-rate bus clock is produced internally as a one-cycle enable pulse, and it is also brought out as a port. The acknowledge and the pin-group output enables change only on fast-clock edges where that pulse is high, so every bus-side transition lines up with a bus-clock rising edge. A request that is dropped before the bus has been floated is abandoned cleanly. A request that is dropped after the float but before the grant sends the bus straight back to driven. In neither case is the acknowledge asserted.

Top module: `bhold_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, hold_ack_n is 1, addr_oe, data_oe and ctl_oe are 1 (driven), and acc_block is 0.
- R2: bus_clk_en is high for exactly one fast-clock cycle out of every CLK_DIV cycles (default 2), and is never high on two cycles in a row.
- R3: hold_ack_n, addr_oe, data_oe and ctl_oe change only on a clock edge at which bus_clk_en is high.
- R4: hold_req_n passes through SYNC_STAGES flip-flops. After it falls, acc_block rises within SYNC_STAGES+CLK_DIV clock edges.
- R5: While acc_pending is 1, the pin groups stay driven and hold_ack_n stays 1. Once acc_pending is 0, the float happens within CLK_DIV edges.
- R6: The three output enables always switch together. hold_ack_n = 0 implies all enables are 0 and acc_block is 1. acc_block stays 1 from the start of the drain until the bus has been driven again for one bus clock.
- R7: The enables fall within SYNC_STAGES+2*CLK_DIV edges of the request falling (with no pending access). hold_ack_n falls exactly CLK_DIV edges after the enables fall.
- R8: After hold_req_n rises, hold_ack_n rises within SYNC_STAGES+CLK_DIV edges. The enables rise exactly CLK_DIV edges after that, and acc_block falls exactly CLK_DIV edges after the enables rise.
- R9: If the request is withdrawn while waiting for pending accesses, the controller returns to idle. hold_ack_n stays 1 and the enables never fall.
- R10: If the request is withdrawn after the float but before the grant, the enables rise again one bus clock later and hold_ack_n is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Active-low bus request from the outside master (asynchronous) |
| acc_pending | input | 1 | High while the access engine has an access in flight |
| acc_block | output | 1 | High: the access engine must not start a new access |
| bus_clk_en | output | 1 | Half-rate bus clock as a one-cycle enable pulse |
| hold_ack_n | output | 1 | Active-low grant to the outside master |
| addr_oe | output | 1 | Output enable for the address pins |
| data_oe | output | 1 | Output enable for the data pins |
| ctl_oe | output | 1 | Output enable for the chip-select and read/write pins |

## Verification
The bench instantiates the block with SYNC_STAGES = 2 and CLK_DIV = 2. With these values the bus-clock phase is fully determined from reset, so each latency can be checked against an exact edge count instead of a window. For the same reason, a withdrawal can be placed precisely inside the drain phase or inside the two-cycle float phase. The short synchronizer keeps the latency bounds tight enough that a single extra register stage anywhere in the path exceeds them.

// File: rtl/bhold_pkg.sv
package bhold_pkg;

    localparam int GRP_ADDR = 0;
    localparam int GRP_DATA = 1;
    localparam int GRP_CTL  = 2;
    localparam int NUM_GRP  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FLOAT,
        ST_GRANT,
        ST_RELEASE,
        ST_REDRIVE
    } hold_state_e;

    typedef struct packed {
        hold_state_e          state;
        logic [NUM_GRP-1:0]   grp_oe;
        logic                 ack_n;
        logic                 block;
    } hold_regs_t;

endpackage

// File: rtl/bhold_sync.sv
module bhold_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/bhold_phase.sv
module bhold_phase #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: a bus-clock pulse is never followed directly by another
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/bhold_fsm.sv
module bhold_fsm
    import bhold_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               req_act,
    input  logic               acc_pending,
    output logic [NUM_GRP-1:0] grp_oe,
    output logic               ack_n,
    output logic               block
);
    hold_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (tick) begin
            case (r_q.state)
                ST_IDLE:    if (req_act) r_d.state = ST_DRAIN;
                ST_DRAIN: begin
                    if (!req_act)          r_d.state = ST_IDLE;
                    else if (!acc_pending) r_d.state = ST_FLOAT;
                end
                ST_FLOAT:   r_d.state = req_act ? ST_GRANT : ST_REDRIVE;
                ST_GRANT:   if (!req_act) r_d.state = ST_RELEASE;
                ST_RELEASE: r_d.state = ST_REDRIVE;
                ST_REDRIVE: r_d.state = ST_IDLE;
                default:    r_d.state = ST_IDLE;
            endcase
        end
        case (r_d.state)
            ST_IDLE, ST_DRAIN, ST_REDRIVE: r_d.grp_oe = '1;
            default:                       r_d.grp_oe = '0;
        endcase
        r_d.ack_n = (r_d.state != ST_GRANT);
        r_d.block = (r_d.state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.grp_oe <= '1;
            r_q.ack_n  <= 1'b1;
            r_q.block  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign grp_oe = r_q.grp_oe;
    assign ack_n  = r_q.ack_n;
    assign block  = r_q.block;

    // R3: pins hold their value between bus-clock edges
    a_r3_bus_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({ack_n, grp_oe}));

    // R6: a grant is only given while the bus floats and accesses are held off
    a_r6_ack_needs_float: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (grp_oe == '0) && block);

    // R6: the bus is floated only while new accesses are blocked
    a_r6_float_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_oe != '1) |-> block);

    // R7: the acknowledge falls only after the bus was already floating
    a_r7_ack_after_float: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> $past(grp_oe == '0));

    // R5: the float starts only with no access pending and the request held
    a_r5_float_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grp_oe[GRP_ADDR]) |-> $past(!acc_pending && req_act && block));

    // R8: the bus is driven again only once the acknowledge is released
    a_r8_redrive_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_oe[GRP_ADDR]) |-> $past(ack_n) && block);

endmodule

// File: rtl/bhold_ctrl.sv
module bhold_ctrl
    import bhold_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CLK_DIV     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_n,
    input  logic acc_pending,
    output logic acc_block,
    output logic bus_clk_en,
    output logic hold_ack_n,
    output logic addr_oe,
    output logic data_oe,
    output logic ctl_oe
);
    logic               req_n_s;
    logic               tick;
    logic [NUM_GRP-1:0] grp_oe;

    bhold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hold_req_n),
        .q     (req_n_s)
    );

    bhold_phase #(.DIV(CLK_DIV)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    bhold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .req_act     (!req_n_s),
        .acc_pending (acc_pending),
        .grp_oe      (grp_oe),
        .ack_n       (hold_ack_n),
        .block       (acc_block)
    );

    assign bus_clk_en = tick;
    assign addr_oe    = grp_oe[GRP_ADDR];
    assign data_oe    = grp_oe[GRP_DATA];
    assign ctl_oe     = grp_oe[GRP_CTL];

endmodule

// File: tb/bhold_ctrl_bench.sv
module bhold_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int DIV  = 2;

    localparam logic [4:0] V_IDLE  = 5'b11110;
    localparam logic [4:0] V_DRAIN = 5'b11111;
    localparam logic [4:0] V_FLOAT = 5'b10001;
    localparam logic [4:0] V_GRANT = 5'b00001;

    localparam int B_ACK = 4;
    localparam int B_OE  = 3;
    localparam int B_BLK = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req_n = 1'b1;
    logic acc_pending = 1'b0;
    logic acc_block, bus_clk_en, hold_ack_n, addr_oe, data_oe, ctl_oe;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [4:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bhold_ctrl #(.SYNC_STAGES(SYNC), .CLK_DIV(DIV)) u_bhold_ctrl (
        .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n),
        .acc_pending(acc_pending), .acc_block(acc_block),
        .bus_clk_en(bus_clk_en), .hold_ack_n(hold_ack_n),
        .addr_oe(addr_oe), .data_oe(data_oe), .ctl_oe(ctl_oe)
    );

    function automatic logic [4:0] obs();
        return {hold_ack_n, addr_oe, data_oe, ctl_oe, acc_block};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_bit(input int idx, input logic val, output int lat);
        logic [4:0] v;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            v = obs();
        end while (v[idx] !== val && lat < 40);
    endtask

    task automatic push_seq(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c,
                            input logic [4:0] d, input logic [4:0] e, input logic [4:0] f,
                            input int n);
        logic [4:0] s[6];
        s[0] = a; s[1] = b; s[2] = c; s[3] = d; s[4] = e; s[5] = f;
        for (int i = 0; i < n; i++) exp_q.push_back(s[i]);
    endtask

    // Monitor: pops the expected output pattern at each observed change
    initial begin
        logic [4:0] prev, cur, e;
        logic prev_tick;
        wait (rst_n === 1'b1);
        @(negedge clk);
        prev = obs();
        prev_tick = bus_clk_en;
        forever begin
            @(negedge clk);
            cur = obs();
            if (cur !== prev) begin
                check(prev_tick === 1'b1, "R3 change off bus edge", int'(prev_tick), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 R10 unexpected output change", int'(cur), int'(prev));
                end else begin
                    e = exp_q.pop_front();
                    check(cur === e, "R6 R7 R8 output sequence", int'(cur), int'(e));
                end
                prev = cur;
            end
            prev_tick = bus_clk_en;
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lat, lat2, ticks;
        logic last_t;
        logic [4:0] v;

        repeat (3) @(negedge clk);
        check(obs() === V_IDLE, "R1 reset outputs", int'(obs()), int'(V_IDLE));
        rst_n = 1'b1;
        @(negedge clk);
        check(obs() === V_IDLE, "R1 after reset", int'(obs()), int'(V_IDLE));

        // R2: pulse rate of the bus clock enable
        ticks = 0;
        last_t = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_clk_en) ticks++;
            if (i > 0) check(!(bus_clk_en && last_t), "R2 back-to-back pulse", 1, 0);
            last_t = bus_clk_en;
        end
        check(ticks == 20 / DIV, "R2 pulse count", ticks, 20 / DIV);

        // Basic hold cycle: R4 R7 R8
        push_seq(V_DRAIN, V_FLOAT, V_GRANT, V_FLOAT, V_DRAIN, V_IDLE, 6);
        hold_req_n = 1'b0;
        wait_bit(B_BLK, 1'b1, lat);
        check(lat <= SYNC + DIV, "R4 block latency", lat, SYNC + DIV);
        wait_bit(B_OE, 1'b0, lat2);
        check(lat + lat2 <= SYNC + 2*DIV, "R7 float latency", lat + lat2, SYNC + 2*DIV);
        v = obs();
        check(v[B_ACK] === 1'b1, "R7 ack not before float", int'(v[B_ACK]), 1);
        wait_bit(B_ACK, 1'b0, lat);
        check(lat == DIV, "R7 ack after float", lat, DIV);
        repeat (10) @(negedge clk);
        check(obs() === V_GRANT, "R6 granted pattern", int'(obs()), int'(V_GRANT));
        hold_req_n = 1'b1;
        wait_bit(B_ACK, 1'b1, lat);
        check(lat <= SYNC + DIV, "R8 ack release latency", lat, SYNC + DIV);
        wait_bit(B_OE, 1'b1, lat);
        check(lat == DIV, "R8 redrive after release", lat, DIV);
        wait_bit(B_BLK, 1'b0, lat);
        check(lat == DIV, "R6 block until redrive done", lat, DIV);

        // Pending accesses hold off the float: R5
        repeat (4) @(negedge clk);
        acc_pending = 1'b1;
        push_seq(V_DRAIN, V_FLOAT, V_GRANT, V_FLOAT, V_DRAIN, V_IDLE, 6);
        hold_req_n = 1'b0;
        wait_bit(B_BLK, 1'b1, lat);
        repeat (12) @(negedge clk);
        check(obs() === V_DRAIN, "R5 bus driven while pending", int'(obs()), int'(V_DRAIN));
        acc_pending = 1'b0;
        wait_bit(B_OE, 1'b0, lat);
        check(lat <= DIV, "R5 float after drain", lat, DIV);
        wait_bit(B_ACK, 1'b0, lat);
        check(lat == DIV, "R7 ack after float (drain)", lat, DIV);
        hold_req_n = 1'b1;
        wait_bit(B_BLK, 1'b0, lat);
        check(lat <= SYNC + 3*DIV, "R8 full release", lat, SYNC + 3*DIV);

        // Withdraw during drain: R9
        repeat (4) @(negedge clk);
        acc_pending = 1'b1;
        push_seq(V_DRAIN, V_IDLE, V_IDLE, V_IDLE, V_IDLE, V_IDLE, 2);
        hold_req_n = 1'b0;
        wait_bit(B_BLK, 1'b1, lat);
        repeat (3) @(negedge clk);
        hold_req_n = 1'b1;
        wait_bit(B_BLK, 1'b0, lat);
        check(lat <= SYNC + DIV, "R9 abandon latency", lat, SYNC + DIV);
        acc_pending = 1'b0;
        repeat (8) @(negedge clk);
        check(obs() === V_IDLE, "R9 idle after abandon", int'(obs()), int'(V_IDLE));

        // Withdraw after float, before grant: R10
        push_seq(V_DRAIN, V_FLOAT, V_DRAIN, V_IDLE, V_IDLE, V_IDLE, 4);
        hold_req_n = 1'b0;
        wait_bit(B_BLK, 1'b1, lat);
        @(negedge clk);
        hold_req_n = 1'b1;
        wait_bit(B_OE, 1'b0, lat);
        check(lat == 1, "R10 float reached", lat, 1);
        wait_bit(B_OE, 1'b1, lat);
        check(lat == DIV, "R10 redrive without grant", lat, DIV);
        wait_bit(B_BLK, 1'b0, lat);
        check(lat == DIV, "R10 block release", lat, DIV);
        repeat (6) @(negedge clk);
        check(obs() === V_IDLE, "R10 final idle", int'(obs()), int'(V_IDLE));

        check(exp_q.size() == 0, "R6 all expected changes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule